// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Word Service Key

The block is a watchdog peripheral on a simple single-cycle register bus. Software first picks a coarse timeout (a 12-bit load value, scaled up by a fixed power of two) together with a service window and a reaction kind. It then arms the watchdog with one exact 32-bit arming word. Once the watchdog is armed, it stays armed until the next hardware reset, and its configuration is frozen.

While armed, a down-counter decrements on every clock. Software keeps the system alive by writing two key words to the key register in a fixed order. The sequence is honoured only while the counter sits inside the chosen window near expiry. In that case the counter reloads. If the counter reaches zero, or if a complete key sequence lands while the window is closed, a sticky cause bit is set in the status register. The reaction output then stays asserted until software clears the cause. The reaction can be routed to a reset request or to a non-maskable interrupt request.

Top module: `windowed_wdog`

## Requirements
- R1: After reset the control register (offset 0x90) reads 0, the load register (0x94) reads 0xFFF, the reaction register (0xA4) reads 0x5, the window register (0xA8) reads 0x05, the status register (0x98) reads 0, the counter (0xA0) reads 0xFFF shifted left by SHIFT, and both reaction outputs are low.
- R2: A write of exactly 0xA98559DA to the control register arms the watchdog. From then on the control register reads back 0xA98559DA. Any other word leaves the watchdog unarmed, and the register then reads 0.
- R3: Once armed, the watchdog stays armed. Writes to the control, load, reaction and window registers are then ignored.
- R4: While unarmed, the counter holds the load value shifted left by SHIFT and follows changes to the load value. While armed, it decreases by one per clock and stops at 0.
- R5: A write of 0x0000E51A followed directly by a write of 0x0000A35C to the key register (0x9C), completed while the window is open, reloads the counter with the load value shifted left by SHIFT.
- R6: The window register accepts 0x05 << (4*k) for k = 0..5. k = 0 keeps the window always open. For k ≥ 1 the window is open when the counter is below the reload value shifted right by k. Any other written value selects k = 0. The register reads back 0x05 << (4*k).
- R7: A key write of any word other than the two key words returns the sequence to its start. A first key word while the second one is awaited restarts the sequence in place. Key writes before arming have no effect.
- R8: If the counter is 0 while armed, status bit 0 sets on the next clock and a reaction output is asserted.
- R9: A complete key sequence while the window is closed sets status bit 1, asserts a reaction output, and leaves the counter counting down without a reload.
- R10: With the reaction register at 0xA, a set status bit drives `react_nmi` and leaves `react_rst` low. With any other reaction value it drives `react_rst` instead. Both outputs are low while the status is 0.
- R11: Writing 1 to a status bit clears it and writing 0 leaves it. A cause present in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one clock per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| react_rst | output | 1 | Reset-request reaction |
| react_nmi | output | 1 | Non-maskable interrupt reaction |

## Verification
The hardest situation to reach from the ports is a key sequence that completes exactly at the window boundary. The window decision uses the counter value one clock before the second key write lands, and that value keeps moving while the writes are issued. The bench uses a small shift so that the reload value is only 32. For every window encoding, plus one invalid encoding, it sweeps the idle delay between arming and servicing across the whole counter range. It predicts the counter at the second key write from the delay alone and then checks for either a reload or a violation.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   localparam logic [7:0] OFS_CTRL = 8'h90;
   localparam logic [7:0] OFS_LOAD = 8'h94;
   localparam logic [7:0] OFS_STAT = 8'h98;
   localparam logic [7:0] OFS_KEY  = 8'h9C;
   localparam logic [7:0] OFS_CNT  = 8'hA0;
   localparam logic [7:0] OFS_ACT  = 8'hA4;
   localparam logic [7:0] OFS_WIN  = 8'hA8;

   localparam logic [31:0] ARM_WORD = 32'hA98559DA;
   localparam logic [31:0] SVC_A    = 32'h0000E51A;
   localparam logic [31:0] SVC_B    = 32'h0000A35C;

   localparam int          ACT_W   = 4;
   localparam logic [3:0]  ACT_NMI = 4'hA;
   localparam logic [3:0]  ACT_RST = 4'h5;

   localparam int          IDX_W   = 3;
   localparam logic [31:0] WIN_BASE = 32'h5;

   typedef enum logic [0:0] {
      KS_IDLE = 1'b0,
      KS_HALF = 1'b1
   } keyseq_t;

endpackage

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
   import wdg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_wr,
   input  logic [31:0] key_data,
   input  logic        win_open,
   output logic        svc_ok,
   output logic        svc_bad
);

   keyseq_t st_q, st_d;
   logic    complete;

   assign complete = key_wr && (st_q == KS_HALF) && (key_data == SVC_B);
   assign svc_ok   = complete && win_open;
   assign svc_bad  = complete && !win_open;

   always_comb begin
      st_d = st_q;
      if (key_wr) begin
         if (key_data == SVC_A) st_d = KS_HALF;
         else                   st_d = KS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
   import wdg_pkg::*;
#(
   parameter int LOAD_W    = 12,
   parameter int SHIFT     = 13,
   parameter int WIN_STEPS = 6,
   localparam int CNT_W    = LOAD_W + SHIFT,
   localparam int NSLOT    = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic [LOAD_W-1:0] load,
   input  logic [IDX_W-1:0]  win_idx,
   input  logic              reload_req,
   output logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  reload_val,
   output logic              win_open,
   output logic              at_zero
);

   localparam logic [CNT_W-1:0] RST_CNT = {{LOAD_W{1'b1}}, {SHIFT{1'b0}}};

   logic [CNT_W-1:0] thr [NSLOT];

   assign reload_val = {load, {SHIFT{1'b0}}};
   assign at_zero    = (cnt == '0);

   for (genvar k = 0; k < NSLOT; k++) begin : g_thr
      if (k < WIN_STEPS) begin : g_used
         assign thr[k] = reload_val >> k;
      end else begin : g_unused
         assign thr[k] = '0;
      end
   end

   assign win_open = (win_idx == '0) ? 1'b1 : (cnt < thr[win_idx]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= RST_CNT;
      else if (!armed)     cnt <= reload_val;
      else if (reload_req) cnt <= reload_val;
      else if (!at_zero)   cnt <= cnt - 1'b1;
   end

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int LOAD_W    = 12,
   parameter int WIN_STEPS = 6,
   parameter int CNT_W     = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              set_expire,
   input  logic              set_viol,
   output logic [31:0]       bus_rdata,
   output logic              armed,
   output logic [LOAD_W-1:0] load,
   output logic [ACT_W-1:0]  act,
   output logic [IDX_W-1:0]  win_idx,
   output logic [1:0]        stat,
   output logic              key_wr
);

   logic             cfg_wr;
   logic [IDX_W-1:0] win_dec;
   logic [1:0]       stat_clr;

   assign cfg_wr = bus_wr && !armed;
   assign key_wr = bus_wr && armed && (bus_addr == OFS_KEY);

   always_comb begin
      win_dec = '0;
      for (int k = 1; k < WIN_STEPS; k++) begin
         if (bus_wdata == (WIN_BASE << (4 * k))) win_dec = IDX_W'(k);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         load    <= '1;
         act     <= ACT_RST;
         win_idx <= '0;
      end else if (cfg_wr) begin
         case (bus_addr)
            OFS_CTRL: armed   <= (bus_wdata == ARM_WORD);
            OFS_LOAD: load    <= bus_wdata[LOAD_W-1:0];
            OFS_ACT:  act     <= bus_wdata[ACT_W-1:0];
            OFS_WIN:  win_idx <= win_dec;
            default:  ;
         endcase
      end
   end

   assign stat_clr = (bus_wr && bus_addr == OFS_STAT) ? bus_wdata[1:0] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= 2'b00;
      else        stat <= (stat & ~stat_clr) | {set_viol, set_expire};
   end

   always_comb begin
      case (bus_addr)
         OFS_CTRL: bus_rdata = armed ? ARM_WORD : 32'h0;
         OFS_LOAD: bus_rdata = 32'(load);
         OFS_STAT: bus_rdata = {30'h0, stat};
         OFS_CNT:  bus_rdata = 32'(cnt);
         OFS_ACT:  bus_rdata = 32'(act);
         OFS_WIN:  bus_rdata = WIN_BASE << (4 * win_idx);
         default:  bus_rdata = 32'h0;
      endcase
   end

endmodule

// File: rtl/windowed_wdog.sv
module windowed_wdog
   import wdg_pkg::*;
#(
   parameter int LOAD_W    = 12,
   parameter int SHIFT     = 13,
   parameter int WIN_STEPS = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        react_rst,
   output logic        react_nmi
);

   localparam int CNT_W = LOAD_W + SHIFT;

   if (CNT_W > 32 || LOAD_W < 1 || SHIFT < 0) begin : g_bad_width
      $error("windowed_wdog: LOAD_W + SHIFT must lie within 1..32");
   end
   if (WIN_STEPS < 1 || WIN_STEPS > (1 << IDX_W)) begin : g_bad_steps
      $error("windowed_wdog: WIN_STEPS must lie within 1..8");
   end

   logic              arm_q;
   logic [LOAD_W-1:0] load_q;
   logic [ACT_W-1:0]  act_q;
   logic [IDX_W-1:0]  win_idx;
   logic [1:0]        stat_q;
   logic              key_wr;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  reload_val;
   logic              win_open;
   logic              at_zero;
   logic              svc_ok;
   logic              svc_bad;
   logic              fault;

   wdg_regs #(
      .LOAD_W    (LOAD_W),
      .WIN_STEPS (WIN_STEPS),
      .CNT_W     (CNT_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .cnt        (cnt_q),
      .set_expire (arm_q && at_zero),
      .set_viol   (svc_bad),
      .bus_rdata  (bus_rdata),
      .armed      (arm_q),
      .load       (load_q),
      .act        (act_q),
      .win_idx    (win_idx),
      .stat       (stat_q),
      .key_wr     (key_wr)
   );

   wdg_counter #(
      .LOAD_W    (LOAD_W),
      .SHIFT     (SHIFT),
      .WIN_STEPS (WIN_STEPS)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .armed      (arm_q),
      .load       (load_q),
      .win_idx    (win_idx),
      .reload_req (svc_ok),
      .cnt        (cnt_q),
      .reload_val (reload_val),
      .win_open   (win_open),
      .at_zero    (at_zero)
   );

   wdg_keyseq u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_data (bus_wdata),
      .win_open (win_open),
      .svc_ok   (svc_ok),
      .svc_bad  (svc_bad)
   );

   assign fault     = |stat_q;
   assign react_nmi = fault && (act_q == ACT_NMI);
   assign react_rst = fault && (act_q != ACT_NMI);

endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
   import wdg_pkg::*;
#(
   parameter int CNT_W = 25
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] reload_val,
   input logic             svc_ok,
   input logic             svc_bad,
   input logic [1:0]       stat_q,
   input logic             bus_wr,
   input logic [7:0]       bus_addr,
   input logic [31:0]      bus_wdata,
   input logic             react_rst,
   input logic             react_nmi
);

   p_arm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      arm_q |=> arm_q);

   p_idle_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_q |=> (cnt_q == $past(reload_val)));

   p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && cnt_q != '0 && !svc_ok) |=> (cnt_q == $past(cnt_q) - 1'b1));

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && svc_ok) |=> (cnt_q == $past(reload_val)));

   p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && cnt_q == '0) |=> stat_q[0]);

   p_viol_r9: assert property (@(posedge clk) disable iff (!rst_n)
      svc_bad |=> stat_q[1]);

   p_react_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(react_rst && react_nmi));

   p_fault_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q != 2'b00) |-> (react_rst || react_nmi));

   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[1] && !(bus_wr && bus_addr == OFS_STAT && bus_wdata[1])) |=> stat_q[1]);

endmodule

bind windowed_wdog wdg_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arm_q      (arm_q),
   .cnt_q      (cnt_q),
   .reload_val (reload_val),
   .svc_ok     (svc_ok),
   .svc_bad    (svc_bad),
   .stat_q     (stat_q),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .react_rst  (react_rst),
   .react_nmi  (react_nmi)
);

// File: tb/tb_windowed_wdog.sv
module tb_windowed_wdog;

   localparam int CLK_PERIOD = 10;
   localparam int LOAD_W     = 12;
   localparam int SHIFT      = 2;
   localparam int WIN_STEPS  = 6;

   localparam logic [7:0] A_CTRL = 8'h90, A_LOAD = 8'h94, A_STAT = 8'h98,
                          A_KEY  = 8'h9C, A_CNT  = 8'hA0, A_ACT  = 8'hA4,
                          A_WIN  = 8'hA8;
   localparam logic [31:0] ARM = 32'hA98559DA, KA = 32'hE51A, KB = 32'hA35C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        react_rst, react_nmi;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   windowed_wdog #(.LOAD_W(LOAD_W), .SHIFT(SHIFT), .WIN_STEPS(WIN_STEPS)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .react_rst(react_rst), .react_nmi(react_nmi));

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      bread(a, v);
      check(tag, v, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      @(negedge clk);
      do_reset();

      // R1 reset state
      expect_reg("R1 ctrl", A_CTRL, 32'h0);
      expect_reg("R1 load", A_LOAD, 32'hFFF);
      expect_reg("R1 act",  A_ACT,  32'h5);
      expect_reg("R1 win",  A_WIN,  32'h5);
      expect_reg("R1 stat", A_STAT, 32'h0);
      expect_reg("R1 cnt",  A_CNT,  32'hFFF << SHIFT);
      check("R1 outputs", {30'h0, react_rst, react_nmi}, 32'h0);

      // R2 wrong arm word; R4 counter held and tracking load; R7 keys unarmed
      bwrite(A_CTRL, 32'h12345678);
      expect_reg("R2 bad arm word", A_CTRL, 32'h0);
      bwrite(A_LOAD, 32'h7);
      idle(3);
      expect_reg("R4 idle tracks load", A_CNT, 32'h7 << SHIFT);
      bwrite(A_KEY, KA); bwrite(A_KEY, KB);
      expect_reg("R7 keys unarmed", A_STAT, 32'h0);

      // R2 arm, R3 freeze
      bwrite(A_LOAD, 32'h8);
      bwrite(A_CTRL, ARM);
      expect_reg("R2 armed readback", A_CTRL, ARM);
      bwrite(A_CTRL, 32'h0);
      bwrite(A_LOAD, 32'h3);
      bwrite(A_ACT, 32'hA);
      bwrite(A_WIN, 32'h50);
      expect_reg("R3 ctrl kept", A_CTRL, ARM);
      expect_reg("R3 load kept", A_LOAD, 32'h8);
      expect_reg("R3 act kept",  A_ACT,  32'h5);
      expect_reg("R3 win kept",  A_WIN,  32'h5);
      expect_reg("R4 decrement", A_CNT,  32'd28);

      // R7 aborted and restarted sequences (full window)
      do_reset();
      bwrite(A_LOAD, 32'h8);
      bwrite(A_CTRL, ARM);
      idle(2);
      bwrite(A_KEY, KA); bwrite(A_KEY, 32'h1234); bwrite(A_KEY, KB);
      expect_reg("R7 abort no reload", A_CNT, 32'd27);
      bwrite(A_KEY, KB);
      expect_reg("R7 lone second key", A_CNT, 32'd26);
      bwrite(A_KEY, KA); bwrite(A_KEY, KA); bwrite(A_KEY, KB);
      expect_reg("R7 restart then reload", A_CNT, 32'd32);
      expect_reg("R7 no violation", A_STAT, 32'h0);

      // R8 expiry, R11 set wins, R5 reload at zero
      do_reset();
      bwrite(A_LOAD, 32'h1);
      bwrite(A_CTRL, ARM);
      idle(4);
      expect_reg("R4 reaches zero", A_CNT, 32'h0);
      expect_reg("R8 not yet", A_STAT, 32'h0);
      idle(1);
      expect_reg("R8 expired bit", A_STAT, 32'h1);
      expect_reg("R4 holds zero", A_CNT, 32'h0);
      check("R10 reset route", {30'h0, react_rst, react_nmi}, 32'h2);
      bwrite(A_STAT, 32'h1);
      expect_reg("R11 cause wins", A_STAT, 32'h1);
      bwrite(A_KEY, KA); bwrite(A_KEY, KB);
      expect_reg("R5 reload from zero", A_CNT, 32'd4);
      bwrite(A_STAT, 32'h1);
      expect_reg("R11 cleared", A_STAT, 32'h0);
      check("R10 outputs low", {30'h0, react_rst, react_nmi}, 32'h0);

      // R9, R10 nmi route, R11 selective clear
      do_reset();
      bwrite(A_ACT, 32'hA);
      bwrite(A_WIN, 32'h50);
      bwrite(A_LOAD, 32'h8);
      bwrite(A_CTRL, ARM);
      bwrite(A_KEY, KA); bwrite(A_KEY, KB);
      expect_reg("R9 early service", A_STAT, 32'h2);
      expect_reg("R9 no reload", A_CNT, 32'd30);
      check("R10 nmi route", {30'h0, react_rst, react_nmi}, 32'h1);
      bwrite(A_STAT, 32'h1);
      expect_reg("R11 zero bit keeps", A_STAT, 32'h2);
      bwrite(A_STAT, 32'h2);
      expect_reg("R11 one bit clears", A_STAT, 32'h0);
      check("R10 nmi low", {30'h0, react_rst, react_nmi}, 32'h0);

      // R6 / R5 / R9 sweep: every window encoding and every service delay
      for (int e = 0; e < 7; e++) begin
         for (int d = 0; d < 28; d++) begin
            logic [31:0] enc;
            int          k;
            int          pre;
            bit          open;
            enc = (e < 6) ? (32'h5 << (4 * e)) : 32'h55;
            k   = (e < 6) ? e : 0;
            do_reset();
            bwrite(A_LOAD, 32'h8);
            bwrite(A_WIN, enc);
            expect_reg("R6 window readback", A_WIN, 32'h5 << (4 * k));
            bwrite(A_CTRL, ARM);
            idle(d);
            expect_reg("R4 count before service", A_CNT, 32'(32 - d));
            pre  = 31 - d;
            open = (k == 0) || (pre < (32 >> k));
            bwrite(A_KEY, KA); bwrite(A_KEY, KB);
            bread(A_CNT, v);
            if (open) begin
               check("R5 R6 reload in window", v, 32'd32);
               expect_reg("R6 no violation", A_STAT, 32'h0);
            end else begin
               check("R9 R6 no reload outside", v, 32'(30 - d));
               expect_reg("R9 violation bit", A_STAT, 32'h2);
               check("R10 reset output", {31'h0, react_rst}, 32'h1);
            end
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule